// File: doc/BRIEF.md
# Reconfigurable-Region Freeze Controller

This block sits between static logic and a region of the device that is reloaded while the rest keeps running. On request it holds the region's boundary (freeze) so that partial outputs cannot disturb the static side, optionally holds the region in reset while it is isolated, and later releases both in a safe order. Software drives it through four 32-bit words: a status word, a control word, a sticky illegal-request word and a read-only version word. The boundary logic reports back through a single acknowledge input that follows the freeze level.

A freeze is a handshake. The controller raises `freeze_o`, waits until the boundary raises `frz_ack_i`, and then reports the freeze as complete. Releasing drops the region reset first, lowers `freeze_o` one cycle later, and reports the unfreeze as complete once the acknowledge has fallen. Requests that break this order are ignored and recorded as a code in the illegal-request word, which only a write-one clears.

Top module: `frz_bridge_ctrl`

## Requirements
- R1: After a synchronous reset, status reads 2 (bit 1 unfreeze-done set, bit 0 freeze-done clear), control and illegal-request read 0, and `freeze_o` and `region_rst_o` are low.
- R2: The word at byte offset 12 reads the parameter VERSION (default 2); writes to it have no effect.
- R3: A control write (offset 4) with bit 0 set, made while the region is unfrozen and idle, raises `freeze_o` in the cycle after the write; status keeps its value until `frz_ack_i` is sampled high, after which status reads 1.
- R4: `region_rst_o` equals control bit 1 only while frozen and idle; it is low in every other state, and writing 0 to control drops it.
- R5: A control write with bit 2 set while frozen and idle lowers `region_rst_o` in the cycle after the write and `freeze_o` one cycle later; status stays 1 until `frz_ack_i` is sampled low, then reads 2.
- R6: A freeze request (control bit 0) made in any state other than unfrozen-and-idle is ignored and sets illegal-request bit 0.
- R7: An unfreeze request (control bit 2) outside the frozen-and-idle state sets illegal-request bit 1, and a reset request (control bit 1) outside that state sets bit 2; the unfreeze is then ignored.
- R8: Illegal-request bits accumulate and stay set; a write to offset 8 with data bit 0 set clears all of them, and a write there with bit 0 clear changes nothing.
- R9: Reads are registered: data appears in the cycle after the read strobe; control reads back its last written bits [2:0], all other bits of every word read 0.
- R10: Status bits 0 and 1 are never set at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | ADDR_W | Byte address of the word |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after `bus_rd` |
| frz_ack_i | input | 1 | Freeze acknowledge from the region boundary |
| freeze_o | output | 1 | Freeze (isolate) the region |
| region_rst_o | output | 1 | Reset toward the region |

## Verification
A wrong sequencer state shows up at the pins within one cycle of the next control write: `freeze_o` or `region_rst_o` take the wrong level right after the write edge, and the illegal-request word reads a code that differs from the one worked out from the written bits and the current phase. A status flag that is set too early or too late is caught by the status read taken between the request and the acknowledge edge. Sweeping all eight control values from both idle phases ties every combination of request bits to its expected code and effect.

// File: rtl/frz_pkg.sv
package frz_pkg;
  typedef enum logic [2:0] {
    ST_OPEN,     // unfrozen, idle
    ST_CLOSING,  // freeze raised, waiting for ack high
    ST_SHUT,     // frozen, idle
    ST_RELEASE,  // region reset dropped, freeze still high
    ST_OPENING   // freeze dropped, waiting for ack low
  } frz_state_t;

  // word indices of the register map (byte offset / 4)
  localparam int W_STAT = 0;
  localparam int W_CTRL = 1;
  localparam int W_ILL  = 2;
  localparam int W_VER  = 3;

  // control bits
  localparam int C_FRZ = 0;
  localparam int C_RST = 1;
  localparam int C_UNF = 2;

  // illegal-request code bits
  localparam int I_FRZ = 0;
  localparam int I_UNF = 1;
  localparam int I_RST = 2;

  localparam int CTL_W = 3;
  localparam int ILL_W = 3;
endpackage

// File: rtl/frz_req_decode.sv
module frz_req_decode
  import frz_pkg::*;
(
  input  logic             ctl_wr,
  input  logic [CTL_W-1:0] ctl_bits,
  input  frz_state_t       state,
  output logic             frz_go,
  output logic             unf_go,
  output logic [ILL_W-1:0] ill_set
);
  logic open_idle, shut_idle;

  always_comb begin
    open_idle = (state == ST_OPEN);
    shut_idle = (state == ST_SHUT);
    frz_go    = ctl_wr && ctl_bits[C_FRZ] && open_idle;
    unf_go    = ctl_wr && ctl_bits[C_UNF] && shut_idle;
    ill_set        = '0;
    ill_set[I_FRZ] = ctl_wr && ctl_bits[C_FRZ] && !open_idle;
    ill_set[I_UNF] = ctl_wr && ctl_bits[C_UNF] && !shut_idle;
    ill_set[I_RST] = ctl_wr && ctl_bits[C_RST] && !shut_idle;
  end
endmodule

// File: rtl/frz_seq.sv
module frz_seq
  import frz_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       frz_go,
  input  logic       unf_go,
  input  logic       ack,
  input  logic       rst_req,
  output frz_state_t state,
  output logic       freeze_q,
  output logic       region_rst_q,
  output logic       frz_done,
  output logic       unf_done
);
  frz_state_t nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_OPEN:    if (frz_go) nxt = ST_CLOSING;
      ST_CLOSING: if (ack)    nxt = ST_SHUT;
      ST_SHUT:    if (unf_go) nxt = ST_RELEASE;
      ST_RELEASE:             nxt = ST_OPENING;
      ST_OPENING: if (!ack)   nxt = ST_OPEN;
      default:                nxt = ST_OPEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_OPEN;
      freeze_q     <= 1'b0;
      region_rst_q <= 1'b0;
      frz_done     <= 1'b0;
      unf_done     <= 1'b1;
    end else begin
      state        <= nxt;
      freeze_q     <= (nxt == ST_CLOSING) || (nxt == ST_SHUT) || (nxt == ST_RELEASE);
      region_rst_q <= (nxt == ST_SHUT) && rst_req;
      frz_done     <= (nxt == ST_SHUT) || (nxt == ST_RELEASE) || (nxt == ST_OPENING);
      unf_done     <= (nxt == ST_OPEN) || (nxt == ST_CLOSING);
    end
  end
endmodule

// File: rtl/frz_csr.sv
module frz_csr
  import frz_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [ILL_W-1:0]  ill_set,
  input  logic              frz_done,
  input  logic              unf_done,
  output logic              ctl_wr,
  output logic [CTL_W-1:0]  ctl_nxt,
  output logic [ILL_W-1:0]  ill_q,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int WIDX_W = ADDR_W - 2;

  logic [WIDX_W-1:0] widx;
  logic [CTL_W-1:0]  ctl_q;
  logic              ill_clr;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_bits;

  assign widx        = bus_addr[ADDR_W-1:2];
  assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:CTL_W]};

  always_comb begin
    ctl_wr  = bus_wr && (widx == WIDX_W'(W_CTRL));
    ill_clr = bus_wr && (widx == WIDX_W'(W_ILL)) && bus_wdata[0];
    ctl_nxt = ctl_wr ? bus_wdata[CTL_W-1:0] : ctl_q;
  end

  always_comb begin
    rd_mux = '0;
    case (widx)
      WIDX_W'(W_STAT): rd_mux = DATA_W'({unf_done, frz_done});
      WIDX_W'(W_CTRL): rd_mux = DATA_W'(ctl_q);
      WIDX_W'(W_ILL):  rd_mux = DATA_W'(ill_q);
      WIDX_W'(W_VER):  rd_mux = DATA_W'(VERSION);
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      ill_q     <= '0;
      bus_rdata <= '0;
    end else begin
      ctl_q <= ctl_nxt;
      if (ill_clr) ill_q <= '0;
      else         ill_q <= ill_q | ill_set;
      if (bus_rd)  bus_rdata <= rd_mux;
    end
  end
endmodule

// File: rtl/frz_bridge_ctrl.sv
module frz_bridge_ctrl
  import frz_pkg::*;
#(
  parameter int          ADDR_W  = 4,
  parameter int          DATA_W  = 32,
  parameter logic [31:0] VERSION = 32'h2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              frz_ack_i,
  output logic              freeze_o,
  output logic              region_rst_o
);
  frz_state_t       state;
  logic             ctl_wr, frz_go, unf_go, frz_done, unf_done;
  logic [CTL_W-1:0] ctl_nxt;
  logic [ILL_W-1:0] ill_set, ill_q;

  frz_csr #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .VERSION(VERSION)) u_csr (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ill_set(ill_set),
    .frz_done(frz_done), .unf_done(unf_done), .ctl_wr(ctl_wr),
    .ctl_nxt(ctl_nxt), .ill_q(ill_q), .bus_rdata(bus_rdata)
  );

  frz_req_decode u_dec (
    .ctl_wr(ctl_wr), .ctl_bits(bus_wdata[CTL_W-1:0]), .state(state),
    .frz_go(frz_go), .unf_go(unf_go), .ill_set(ill_set)
  );

  frz_seq u_seq (
    .clk(clk), .rst(rst), .frz_go(frz_go), .unf_go(unf_go),
    .ack(frz_ack_i), .rst_req(ctl_nxt[C_RST]), .state(state),
    .freeze_q(freeze_o), .region_rst_q(region_rst_o),
    .frz_done(frz_done), .unf_done(unf_done)
  );
endmodule

// File: rtl/frz_bridge_ctrl_chk.sv
module frz_bridge_ctrl_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              frz_ack_i,
  input logic              freeze_o,
  input logic              region_rst_o,
  input logic              frz_done,
  input logic              unf_done,
  input logic [2:0]        ill_q
);
  logic ill_clear;
  assign ill_clear = bus_wr && (bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2)) && bus_wdata[0];

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (unf_done && !frz_done && !freeze_o && !region_rst_o && ill_q == 3'b000));

  p_freeze_from_open_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(freeze_o) |-> $past(unf_done));

  p_done_needs_ack_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(frz_done) |-> $past(frz_ack_i));

  p_reset_only_frozen_r4: assert property (@(posedge clk) disable iff (rst)
    region_rst_o |-> (freeze_o && frz_done));

  p_release_order_r5: assert property (@(posedge clk) disable iff (rst)
    $fell(freeze_o) |-> !$past(region_rst_o));

  p_open_needs_ack_low_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(unf_done) |-> !$past(frz_ack_i));

  p_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    (|($past(ill_q) & ~ill_q)) |-> $past(ill_clear));

  p_flags_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(frz_done && unf_done));
endmodule

bind frz_bridge_ctrl frz_bridge_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .frz_ack_i(frz_ack_i), .freeze_o(freeze_o),
  .region_rst_o(region_rst_o), .frz_done(frz_done), .unf_done(unf_done),
  .ill_q(ill_q)
);

// File: tb/frz_bridge_ctrl_bench.sv
module frz_bridge_ctrl_bench;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam logic [3:0] A_STAT = 4'd0, A_CTRL = 4'd4, A_ILL = 4'd8, A_VER = 4'd12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_wr = 1'b0, bus_rd = 1'b0, frz_ack_i = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;
  logic freeze_o, region_rst_o;
  int checks = 0;
  int fails = 0;
  logic [31:0] rv;

  always #2 clk = ~clk;

  frz_bridge_ctrl #(.ADDR_W(AW), .DATA_W(DW), .VERSION(32'h2)) u_frz_bridge_ctrl (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frz_ack_i(frz_ack_i),
    .freeze_o(freeze_o), .region_rst_o(region_rst_o)
  );

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic go_frozen();
    wr(A_CTRL, 32'h1);
    frz_ack_i = 1'b1;
    tick();
  endtask

  task automatic go_open();
    wr(A_CTRL, 32'h4);
    tick();
    frz_ack_i = 1'b0;
    tick();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: got 0x%08h expected 0x%08h", 32'h1, 32'h0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (4) tick();
    rst = 1'b0;
    // R1 reset state
    check("R1 freeze_o", 32'(freeze_o), 32'h0);
    check("R1 region_rst_o", 32'(region_rst_o), 32'h0);
    rd(A_STAT, rv); check("R1 status", rv, 32'h2);
    rd(A_CTRL, rv); check("R1 control", rv, 32'h0);
    rd(A_ILL, rv);  check("R1 illegal", rv, 32'h0);
    // R2 version, read-only
    rd(A_VER, rv); check("R2 version", rv, 32'h2);
    wr(A_VER, 32'hFFFF_FFFF);
    rd(A_VER, rv); check("R2 version after write", rv, 32'h2);
    // R9 control readback, upper bits zero
    wr(A_CTRL, 32'hFFFF_FFF8);
    rd(A_CTRL, rv); check("R9 control upper bits", rv, 32'h0);

    // R3 handshake with delayed ack, requests during the freeze in progress
    wr(A_CTRL, 32'h1);
    check("R3 freeze_o after write", 32'(freeze_o), 32'h1);
    rd(A_STAT, rv); check("R3 status before ack", rv, 32'h2);
    wr(A_CTRL, 32'h1);
    rd(A_ILL, rv); check("R6 freeze while closing", rv, 32'h1);
    wr(A_CTRL, 32'h4);
    rd(A_ILL, rv); check("R7 unfreeze while closing", rv, 32'h3);
    // R8 sticky, write-one clear
    wr(A_ILL, 32'h0);
    rd(A_ILL, rv); check("R8 write zero keeps", rv, 32'h3);
    wr(A_ILL, 32'h1);
    rd(A_ILL, rv); check("R8 write one clears", rv, 32'h0);
    frz_ack_i = 1'b1;
    tick();
    rd(A_STAT, rv); check("R3 status after ack", rv, 32'h1);
    check("R10 freeze held", 32'(freeze_o), 32'h1);
    // R5 ordered release with late ack drop
    wr(A_CTRL, 32'h2);
    check("R4 reset follows bit1", 32'(region_rst_o), 32'h1);
    rd(A_CTRL, rv); check("R9 control readback", rv, 32'h2);
    wr(A_CTRL, 32'h4);
    check("R5 reset dropped first", 32'(region_rst_o), 32'h0);
    check("R5 freeze still high", 32'(freeze_o), 32'h1);
    tick();
    check("R5 freeze dropped next cycle", 32'(freeze_o), 32'h0);
    rd(A_STAT, rv); check("R5 status before ack low", rv, 32'h1);
    frz_ack_i = 1'b0;
    tick();
    rd(A_STAT, rv); check("R5 status after ack low", rv, 32'h2);

    // sweep every control value from the unfrozen idle phase
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      logic [31:0] e;
      b = 3'(v);
      wr(A_ILL, 32'h1);
      wr(A_CTRL, 32'(v));
      check("R3 sweep open freeze_o", 32'(freeze_o), 32'(b[0]));
      check("R4 sweep open reset low", 32'(region_rst_o), 32'h0);
      e = (32'(b[2]) << 1) | (32'(b[1]) << 2);
      rd(A_ILL, rv); check("R7 sweep open code", rv, e);
      if (b[0]) begin
        frz_ack_i = 1'b1;
        tick();
        rd(A_STAT, rv); check("R10 sweep open status", rv, 32'h1);
        check("R4 sweep frozen reset", 32'(region_rst_o), 32'(b[1]));
        wr(A_CTRL, 32'h0);
        check("R4 write zero drops reset", 32'(region_rst_o), 32'h0);
        go_open();
      end
      rd(A_STAT, rv); check("R10 sweep open back", rv, 32'h2);
    end

    // sweep every control value from the frozen idle phase
    for (int v = 0; v < 8; v++) begin
      logic [2:0] b;
      b = 3'(v);
      go_frozen();
      wr(A_ILL, 32'h1);
      wr(A_CTRL, 32'(v));
      check("R4 sweep shut reset", 32'(region_rst_o), b[2] ? 32'h0 : 32'(b[1]));
      check("R6 sweep shut freeze_o", 32'(freeze_o), 32'h1);
      rd(A_ILL, rv); check("R6 sweep shut code", rv, 32'(b[0]));
      if (b[2]) begin
        check("R5 sweep freeze low after release", 32'(freeze_o), 32'h0);
        frz_ack_i = 1'b0;
        tick();
      end else begin
        wr(A_CTRL, 32'h0);
        go_open();
      end
      rd(A_STAT, rv); check("R5 sweep shut back open", rv, 32'h2);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule